// File: doc/BRIEF.md
# PLL Divider Programming Sequencer

This block brings up a PHY's PLL by programming its controller over a small register bus. A start pulse comes with a code that names the reference clock rate. The block turns that code into a set of divider settings: feedback multiplier, pre-divider, oscillator range select, sigma-delta setting and fractional multiplier. It then updates one field at a time. For each field it reads the register that holds it, replaces only that field's bits and writes the word back. When all five fields are done it writes the go command and keeps reading the status register until the lock bit shows up or a time bound runs out.

The result is given on flags that stay valid until the next accepted start. locked means the PLL reported lock. err means the rate code was not supported, and in that case no bus traffic happens. timeout means lock never appeared within the bound. A one-cycle done pulse marks the end of every run. The bus allows one transaction at a time. A write is taken in the cycle its request is raised. A read is answered some cycles later by a read-valid strobe that carries the data.

Top module: `pll_prog_seq`

## Requirements
- R1: Rate codes 0 to 4 select 12, 16.8, 19.2, 26 and 38.4 MHz. For each code the values (multiplier, pre-divider, range select, sigma-delta, fraction) are: 0 → (1250, 5, 4, 20, 0); 1 → (3125, 20, 4, 20, 0); 2 → (1172, 8, 4, 20, 65537); 3 → (1250, 12, 4, 20, 0); 4 → (3125, 47, 4, 20, 92843).
- R2: Codes 5 to 7 are rejected. The cycle after the start, done and err are high, and no bus request is ever raised.
- R3: The field positions are fixed. Register 0x0C holds the pre-divider in bits 8:1 and the multiplier in bits 20:9. Register 0x10 holds the range select in bits 3:1. Register 0x14 holds the sigma-delta value in bits 16:9. Register 0x20 holds the fraction in bits 17:0. Every other bit keeps the value that was read.
- R4: The bus writes come in a fixed order: pre-divider (0x0C), range select (0x10), multiplier (0x0C), fraction (0x20), sigma-delta (0x14). Each write is preceded by a read of the same address. After the fifth write comes one write of value 1 to address 0x08.
- R5: Only one transaction is in flight at a time. No request is raised between a read request and its read-valid response. Each field write carries the data of the read just before it, with only that field changed.
- R6: After the go write, the block reads address 0x04 again and again. A response with bit 1 set ends the run with done and locked. No other status bit is looked at.
- R7: The lock wait lasts LOCK_WAIT_CYCLES = CLK_HZ/1000*LOCK_TIMEOUT_MS cycles. Time counts from 0 in the cycle after the go write. The run ends with done and timeout on the first status response that has bit 1 clear and arrives when the count is at least LOCK_WAIT_CYCLES.
- R8: A status response that has bit 1 set and arrives once the wait has expired ends the run as locked, not as timed out.
- R9: A start that arrives while busy is ignored. The run carries on with its original rate, and err stays low.
- R10: After reset, every output is low. done lasts exactly one cycle, and exactly one of locked, err and timeout goes with it. That flag holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request pulse |
| rate_i | input | 3 | Reference-rate code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| locked_o | output | 1 | Run ended with lock |
| err_o | output | 1 | Run rejected for an unsupported rate |
| timeout_o | output | 1 | Lock wait expired |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | 8 | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_rvalid_i | input | 1 | Read response valid |
| bus_rdata_i | input | 32 | Read response data |

## Verification
Two things can land on the same status response: the lock wait running out, and the lock bit being set. The bench makes this happen with a one-cycle read latency, where status responses arrive at wait counts 1, 3, 5 and so on. With a 200-cycle bound, read 101 (count 201) is the first response past expiry. A plain timeout run is judged on ending after exactly 101 status reads. The collision run has the lock bit first appear on read 101, and it must end locked with timeout low.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int RATE_W    = 3;
    localparam int NUM_RATES = 5;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int LOCK_BIT  = 1;

    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_GO     = 8'h08;
    localparam logic [7:0] OFS_CFG1   = 8'h0C;
    localparam logic [7:0] OFS_CFG2   = 8'h10;
    localparam logic [7:0] OFS_CFG3   = 8'h14;
    localparam logic [7:0] OFS_CFG4   = 8'h20;

    localparam int MUL_W  = 12;
    localparam int PDIV_W = 8;
    localparam int RSEL_W = 3;
    localparam int SDM_W  = 8;
    localparam int FRAC_W = 18;

    typedef struct packed {
        logic [MUL_W-1:0]  mul;
        logic [PDIV_W-1:0] pdiv;
        logic [RSEL_W-1:0] rsel;
        logic [SDM_W-1:0]  sdm;
        logic [FRAC_W-1:0] frac;
    } pll_div_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR,
        ST_GO,
        ST_POLL_REQ,
        ST_POLL_WAIT
    } seq_state_e;

    // step order: 0 pre-divider, 1 range select, 2 multiplier, 3 fraction, 4 sigma-delta
    function automatic logic [7:0] step_addr(int s);
        case (s)
            0:       return OFS_CFG1;
            1:       return OFS_CFG2;
            2:       return OFS_CFG1;
            3:       return OFS_CFG4;
            default: return OFS_CFG3;
        endcase
    endfunction

    function automatic int step_lsb(int s);
        case (s)
            0:       return 1;
            1:       return 1;
            2:       return 9;
            3:       return 0;
            default: return 9;
        endcase
    endfunction

    function automatic int step_width(int s);
        case (s)
            0:       return PDIV_W;
            1:       return RSEL_W;
            2:       return MUL_W;
            3:       return FRAC_W;
            default: return SDM_W;
        endcase
    endfunction

    function automatic logic [31:0] step_value(pll_div_t d, int s);
        case (s)
            0:       return 32'(d.pdiv);
            1:       return 32'(d.rsel);
            2:       return 32'(d.mul);
            3:       return 32'(d.frac);
            default: return 32'(d.sdm);
        endcase
    endfunction

endpackage

// File: rtl/pll_div_table.sv
module pll_div_table
    import pll_seq_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    output pll_div_t          div_o,
    output logic              valid_o
);

    always_comb begin
        valid_o = 1'b1;
        div_o   = '0;
        case (rate_i)
            3'd0: div_o = '{mul: 12'd1250, pdiv: 8'd5,  rsel: 3'd4, sdm: 8'd20, frac: 18'd0};
            3'd1: div_o = '{mul: 12'd3125, pdiv: 8'd20, rsel: 3'd4, sdm: 8'd20, frac: 18'd0};
            3'd2: div_o = '{mul: 12'd1172, pdiv: 8'd8,  rsel: 3'd4, sdm: 8'd20, frac: 18'd65537};
            3'd3: div_o = '{mul: 12'd1250, pdiv: 8'd12, rsel: 3'd4, sdm: 8'd20, frac: 18'd0};
            3'd4: div_o = '{mul: 12'd3125, pdiv: 8'd47, rsel: 3'd4, sdm: 8'd20, frac: 18'd92843};
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pll_field_merge.sv
module pll_field_merge
    import pll_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [STEP_W-1:0] step_i,
    input  pll_div_t          div_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic [7:0]        addr_o,
    output logic [DATA_W-1:0] merged_o
);

    logic [DATA_W-1:0] lane [NUM_STEPS];

    for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_lane
        localparam int LSB = step_lsb(gi);
        localparam int W   = step_width(gi);
        logic [31:0]       ones;
        logic [DATA_W-1:0] fmask;
        logic [DATA_W-1:0] fval;
        assign ones     = (32'd1 << W) - 32'd1;
        assign fmask    = DATA_W'(ones << LSB);
        assign fval     = DATA_W'(step_value(div_i, gi) << LSB);
        assign lane[gi] = (rd_i & ~fmask) | (fval & fmask);
    end

    always_comb begin
        merged_o = rd_i;
        addr_o   = step_addr(NUM_STEPS - 1);
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (step_i == STEP_W'(i)) begin
                merged_o = lane[i];
                addr_o   = step_addr(i);
            end
        end
    end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q >= CW'(LIMIT));

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_HZ          = 250_000_000,
    parameter int LOCK_TIMEOUT_MS = 20,
    parameter int DATA_W          = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              locked_o,
    output logic              err_o,
    output logic              timeout_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [7:0]        bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_rvalid_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);

    localparam int LOCK_WAIT_CYCLES = (CLK_HZ / 1000) * LOCK_TIMEOUT_MS;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [RATE_W-1:0] rate;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic              locked;
        logic              err;
        logic              timeout;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [RATE_W-1:0] lookup_rate;
    pll_div_t          div;
    logic              rate_ok;
    logic [7:0]        field_addr;
    logic [DATA_W-1:0] field_word;
    logic              wait_expired;

    assign lookup_rate = (r_q.state == ST_IDLE) ? rate_i : r_q.rate;

    pll_div_table i_table (
        .rate_i  (lookup_rate),
        .div_o   (div),
        .valid_o (rate_ok)
    );

    pll_field_merge #(.DATA_W(DATA_W)) i_merge (
        .step_i   (r_q.step),
        .div_i    (div),
        .rd_i     (bus_rdata_i),
        .addr_o   (field_addr),
        .merged_o (field_word)
    );

    pll_lock_timer #(.LIMIT(LOCK_WAIT_CYCLES)) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (r_q.state == ST_GO),
        .expired_o (wait_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.locked  = 1'b0;
                    r_d.err     = 1'b0;
                    r_d.timeout = 1'b0;
                    if (!rate_ok) begin
                        r_d.err  = 1'b1;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.rate  = rate_i;
                        r_d.step  = '0;
                        r_d.state = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ: r_d.state = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (bus_rvalid_i) begin
                    r_d.wdata = field_word;
                    r_d.state = ST_WR;
                end
            end
            ST_WR: begin
                if (r_q.step == STEP_W'(NUM_STEPS - 1)) begin
                    r_d.state = ST_GO;
                end else begin
                    r_d.step  = r_q.step + 1'b1;
                    r_d.state = ST_RD_REQ;
                end
            end
            ST_GO:       r_d.state = ST_POLL_REQ;
            ST_POLL_REQ: r_d.state = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (bus_rvalid_i) begin
                    if (bus_rdata_i[LOCK_BIT]) begin
                        r_d.locked = 1'b1;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else if (wait_expired) begin
                        r_d.timeout = 1'b1;
                        r_d.done    = 1'b1;
                        r_d.state   = ST_IDLE;
                    end else begin
                        r_d.state = ST_POLL_REQ;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        case (r_q.state)
            ST_RD_REQ: begin
                bus_req_o  = 1'b1;
                bus_addr_o = field_addr;
            end
            ST_WR: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = field_addr;
                bus_wdata_o = r_q.wdata;
            end
            ST_GO: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = OFS_GO;
                bus_wdata_o = DATA_W'(1);
            end
            ST_POLL_REQ: begin
                bus_req_o  = 1'b1;
                bus_addr_o = OFS_STATUS;
            end
            default: ;
        endcase
    end

    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;
    assign locked_o  = r_q.locked;
    assign err_o     = r_q.err;
    assign timeout_o = r_q.timeout;

endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [2:0]        rate_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              locked_o,
    input logic              err_o,
    input logic              timeout_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [7:0]        bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_rvalid_i,
    input logic [DATA_W-1:0] bus_rdata_i
);

    logic rd_pend;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_pend <= 1'b0;
        end else if (bus_req_o && !bus_we_o) begin
            rd_pend <= 1'b1;
        end else if (bus_rvalid_i) begin
            rd_pend <= 1'b0;
        end
    end

    assert_one_outstanding_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_pend |-> !bus_req_o);

    assert_bad_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && rate_i > 3'd4) |=> (done_o && err_o && !busy_o && !bus_req_o));

    assert_go_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_we_o && bus_addr_o == 8'h08) |-> (bus_wdata_o == DATA_W'(1)));

    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_one_outcome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($countones({locked_o, err_o, timeout_o}) == 1));

    assert_no_err_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !err_o);

    assert_lock_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> ($past(bus_rvalid_i) && $past(bus_rdata_i[1])));

    assert_timeout_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> ($past(bus_rvalid_i) && !$past(bus_rdata_i[1])));

endmodule

bind pll_prog_seq pll_prog_seq_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  rate = 3'd0;
    logic        busy, done, locked, err, tmo;
    logic        req, we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        rvalid = 1'b0;
    logic [31:0] rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pll_prog_seq #(.CLK_HZ(10_000), .LOCK_TIMEOUT_MS(20)) i_pll_prog_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate),
        .busy_o(busy), .done_o(done), .locked_o(locked), .err_o(err), .timeout_o(tmo),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_rvalid_i(rvalid), .bus_rdata_i(rdata)
    );

    // ---- register-file model of the PLL controller ----
    logic        load_req = 1'b0;
    logic [31:0] init_pat = '0;
    int          lat = 1;
    int          lock_on_read = 0;
    logic [31:0] mem [16];
    logic [7:0]  wlog [16];
    logic [31:0] wdlog [16];
    logic [7:0]  rlog [16];
    int          wr_n, rd_n, st_rd, viol, cnt;
    logic [7:0]  pend_addr;
    int          pend_st;
    logic        pend;

    function automatic logic [31:0] model_val(logic [7:0] a, int stn);
        if (a == 8'h04)
            return (lock_on_read != 0 && stn >= lock_on_read) ? 32'h0000_0002 : 32'hFFFF_FFFD;
        return mem[a[5:2]];
    endfunction

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_pat;
            wr_n <= 0; rd_n <= 0; st_rd <= 0; viol <= 0; cnt <= 0;
            pend <= 1'b0; rvalid <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            if (rvalid) pend <= 1'b0;
            if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    rvalid <= 1'b1;
                    rdata  <= model_val(pend_addr, pend_st);
                end
            end
            if (req) begin
                if (pend) viol <= viol + 1;
                if (we) begin
                    mem[addr[5:2]] <= wdata;
                    if (wr_n < 16) begin
                        wlog[wr_n]  <= addr;
                        wdlog[wr_n] <= wdata;
                    end
                    wr_n <= wr_n + 1;
                end else begin
                    pend <= 1'b1;
                    if (addr == 8'h04) st_rd <= st_rd + 1;
                    else begin
                        if (rd_n < 16) rlog[rd_n] <= addr;
                        rd_n <= rd_n + 1;
                    end
                    if (lat <= 1) begin
                        rvalid <= 1'b1;
                        rdata  <= model_val(addr, st_rd + 1);
                    end else begin
                        cnt       <= lat - 1;
                        pend_addr <= addr;
                        pend_st   <= st_rd + 1;
                    end
                end
            end
        end
    end

    // ---- helpers ----
    task automatic check(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
        end
    endtask

    // expected divider values, code -> {mul, pdiv, rsel, sdm, frac}
    task automatic exp_div(int code, output int m, output int n, output int d, output int s, output int f);
        d = 4; s = 20;
        case (code)
            0: begin m = 1250; n = 5;  f = 0;     end
            1: begin m = 3125; n = 20; f = 0;     end
            2: begin m = 1172; n = 8;  f = 65537; end
            3: begin m = 1250; n = 12; f = 0;     end
            default: begin m = 3125; n = 47; f = 92843; end
        endcase
    endtask

    task automatic load_model(logic [31:0] pat, int latency, int lock_read);
        @(negedge clk);
        init_pat = pat; lat = latency; lock_on_read = lock_read;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic pulse_start(logic [2:0] code);
        start = 1'b1; rate = code;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        check("R10", "busy after reset", 32'(busy), 0);
        check("R10", "done after reset", 32'(done), 0);
        check("R10", "flags after reset", 32'({locked, err, tmo}), 0);
        check("R10", "bus_req after reset", 32'(req), 0);
    endtask

    task automatic t_bad_rate(logic [2:0] code);
        int ok;
        load_model(32'h1111_2222, 1, 1);
        pulse_start(code);
        check("R2", "done cycle after bad start", 32'(done), 1);
        check("R2", "err on bad rate", 32'(err), 1);
        check("R2", "busy on bad rate", 32'(busy), 0);
        repeat (4) @(negedge clk);
        check("R2", "no writes on bad rate", 32'(wr_n), 0);
        check("R2", "no reads on bad rate", 32'(rd_n + st_rd), 0);
        check("R10", "err held", 32'(err), 1);
        ok = 1;
    endtask

    task automatic check_regs(int code, logic [31:0] pat);
        int m, n, d, s, f;
        logic [31:0] e1, e2, e3, e4;
        exp_div(code, m, n, d, s, f);
        e1 = (pat & ~(32'hFF << 1) & ~(32'hFFF << 9)) | (32'(n) << 1) | (32'(m) << 9);
        e2 = (pat & ~(32'h7 << 1)) | (32'(d) << 1);
        e3 = (pat & ~(32'hFF << 9)) | (32'(s) << 9);
        e4 = (pat & ~32'h3FFFF) | 32'(f);
        check("R1", "config 0x0C multiplier/pre-divider", mem[3], e1);
        check("R3", "config 0x10 range select", mem[4], e2);
        check("R3", "config 0x14 sigma-delta", mem[5], e3);
        check("R1", "config 0x20 fraction", mem[8], e4);
    endtask

    task automatic t_program(int code, logic [31:0] pat, int latency, int lock_read);
        int ok;
        load_model(pat, latency, lock_read);
        pulse_start(3'(code));
        check("R9", "busy after start", 32'(busy), 1);
        wait_done(ok);
        check("R6", "run finished", 32'(ok), 1);
        check("R6", "locked", 32'(locked), 1);
        check("R10", "other flags clear", 32'({err, tmo}), 0);
        check("R6", "status reads", 32'(st_rd), 32'(lock_read));
        @(negedge clk);
        check("R10", "done one cycle", 32'(done), 0);
        check("R10", "locked held", 32'(locked), 1);
        check("R4", "write count", 32'(wr_n), 6);
        check("R4", "field read count", 32'(rd_n), 5);
        check("R4", "write 0 addr", 32'(wlog[0]), 32'h0C);
        check("R4", "write 1 addr", 32'(wlog[1]), 32'h10);
        check("R4", "write 2 addr", 32'(wlog[2]), 32'h0C);
        check("R4", "write 3 addr", 32'(wlog[3]), 32'h20);
        check("R4", "write 4 addr", 32'(wlog[4]), 32'h14);
        check("R4", "go addr", 32'(wlog[5]), 32'h08);
        check("R4", "go data", wdlog[5], 32'h1);
        for (int i = 0; i < 5; i++)
            check("R4", "read precedes write", 32'(rlog[i]), 32'(wlog[i]));
        check("R5", "no overlapped requests", 32'(viol), 0);
        check_regs(code, pat);
    endtask

    task automatic t_timeout();
        int ok;
        load_model(32'hFFFF_FFFF, 1, 0);
        pulse_start(3'd3);
        wait_done(ok);
        check("R7", "timeout run finished", 32'(ok), 1);
        check("R7", "timeout flag", 32'(tmo), 1);
        check("R7", "not locked", 32'(locked), 0);
        check("R7", "status reads to expiry", 32'(st_rd), 101);
        @(negedge clk);
        check("R10", "timeout held", 32'(tmo), 1);
    endtask

    task automatic t_collision();
        int ok;
        load_model(32'h0F0F_F0F0, 1, 101);
        pulse_start(3'd4);
        wait_done(ok);
        check("R8", "collision finished", 32'(ok), 1);
        check("R8", "lock wins at expiry", 32'(locked), 1);
        check("R8", "no timeout at collision", 32'(tmo), 0);
        check("R8", "reads at collision", 32'(st_rd), 101);
    endtask

    task automatic t_busy_start();
        int ok;
        load_model(32'hA5A5_5A5A, 3, 2);
        pulse_start(3'd2);
        repeat (5) @(negedge clk);
        pulse_start(3'd7);
        check("R9", "err stays low", 32'(err), 0);
        repeat (10) @(negedge clk);
        pulse_start(3'd0);
        wait_done(ok);
        check("R9", "run finished", 32'(ok), 1);
        check("R9", "locked", 32'(locked), 1);
        check("R9", "err low", 32'(err), 0);
        @(negedge clk);
        check("R9", "write count unchanged", 32'(wr_n), 6);
        check_regs(2, 32'hA5A5_5A5A);
    endtask

    initial begin
        #600000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_rate(3'd5);
        t_bad_rate(3'd7);
        t_program(0, 32'hFFFF_FFFF, 1, 1);
        t_program(1, 32'h0000_0000, 3, 3);
        t_program(2, 32'hA5A5_5A5A, 2, 5);
        t_timeout();
        t_program(3, 32'h1234_5678, 1, 2);
        t_program(4, 32'hFFFF_FFFF, 4, 4);
        t_collision();
        t_busy_start();
        t_bad_rate(3'd6);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule